// File: doc/BRIEF.md
# Push-Button Switch with Idle Timeout

This block is a two-mode controller driven by one push-button level. It comes out of reset in the off mode. A cycle in which the button is high switches it on. While it is on, the block counts the cycles in which the button stays low. A second press switches it off. When the idle count reaches a limit, it also switches off by itself. Each clock cycle is one evaluation round. The press input is taken as a level, so every cycle with the input high counts as a press.

The mode and the idle count are registered and are both visible at the ports. A host can therefore drive indicator logic and follow the time left before the automatic shut-off. The timeout limit is a parameter, 10 by default. The counter is sized so that it holds the limit without wrapping. Debouncing and edge detection of a raw button are left to logic in front of the block.

Top module: `pb_autooff_switch`

## Requirements
- R1: During and right after a synchronous active-high reset, `on_o` is 0 and `count_o` is 0.
- R2: In the off mode (`on_o` = 0), a cycle with `press_i` = 1 makes `on_o` 1 after that clock edge, and `count_o` stays 0.
- R3: In the off mode, a cycle with `press_i` = 0 leaves `on_o` at 0 and `count_o` at 0.
- R4: In the on mode, a cycle with `press_i` = 0 and `count_o` below LIMIT keeps `on_o` at 1 and raises `count_o` by exactly one.
- R5: In the on mode, a cycle with `press_i` = 1 makes `on_o` 0 and `count_o` 0 after the edge, whatever the count was.
- R6: In the on mode, a cycle with `press_i` = 0 and `count_o` equal to LIMIT makes `on_o` 0 and `count_o` 0 after the edge. With the default LIMIT, the block stays on for 11 idle cycles.
- R7: `count_o` never exceeds LIMIT.
- R8: Whenever `on_o` is 0, `count_o` is 0.
- R9: Reset takes priority over every transition, including a press in either mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one round per rising edge |
| rst | input | 1 | Synchronous reset, active high |
| press_i | input | 1 | Button level, sampled once per cycle |
| on_o | output | 1 | Registered mode: 1 = on, 0 = off |
| count_o | output | CNT_W | Registered idle-cycle count |

## Verification
The assertions check four behaviours on every cycle: the bound on the count, the zero count whenever the block is off, the single-step increment while it is idle and on, and the mode changes caused by a press or by the limit. Some behaviours only the bench scenarios can show. These are the full timeout length of 11 idle cycles, a press that lands exactly at the limit, a held button toggling the mode on each cycle, and reset winning over a simultaneous press. The bench shows them by comparing the outputs against a behavioural model along those sequences.

// File: rtl/pbsw_pkg.sv
package pbsw_pkg;
  typedef enum logic {
    MODE_OFF = 1'b0,
    MODE_ON  = 1'b1
  } mode_e;
endpackage

// File: rtl/pbsw_idle_tally.sv
module pbsw_idle_tally #(
  parameter int unsigned LIMIT = 10,
  parameter int unsigned CW    = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          active,
  input  logic          press,
  output logic [CW-1:0] count,
  output logic          at_limit
);
  localparam logic [CW-1:0] LIM_V = CW'(LIMIT);

  assign at_limit = (count >= LIM_V);

  // Count idle cycles while on; any other case returns to zero.
  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (active && !press && !at_limit) begin
      count <= count + 1'b1;
    end else begin
      count <= '0;
    end
  end

  p_count_bounded_r7: assert property (@(posedge clk) disable iff (rst)
    count <= LIM_V);

  p_idle_step_r4: assert property (@(posedge clk) disable iff (rst)
    (active && !press && !at_limit) |=> (count == $past(count) + 1'b1));

  p_press_clears_r5: assert property (@(posedge clk) disable iff (rst)
    (active && press) |=> (count == '0));
endmodule

// File: rtl/pbsw_mode_fsm.sv
module pbsw_mode_fsm
  import pbsw_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  press,
  input  logic  expire,
  output mode_e mode
);
  mode_e mode_nx;

  always_comb begin
    mode_nx = mode;
    case (mode)
      MODE_OFF: if (press) mode_nx = MODE_ON;
      MODE_ON:  if (press || expire) mode_nx = MODE_OFF;
      default:  mode_nx = MODE_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) mode <= MODE_OFF;
    else     mode <= mode_nx;
  end

  p_wake_on_press_r2: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_OFF && press) |=> (mode == MODE_ON));

  p_stay_off_r3: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_OFF && !press) |=> (mode == MODE_OFF));

  p_press_off_r5: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_ON && press) |=> (mode == MODE_OFF));

  p_timeout_off_r6: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_ON && expire && !press) |=> (mode == MODE_OFF));
endmodule

// File: rtl/pb_autooff_switch.sv
module pb_autooff_switch
  import pbsw_pkg::*;
#(
  parameter int unsigned LIMIT = 10,
  parameter int unsigned CNT_W = $clog2(LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             press_i,
  output logic             on_o,
  output logic [CNT_W-1:0] count_o
);
  mode_e mode;
  logic  expire;

  pbsw_mode_fsm u_mode (
    .clk    (clk),
    .rst    (rst),
    .press  (press_i),
    .expire (expire),
    .mode   (mode)
  );

  pbsw_idle_tally #(.LIMIT(LIMIT), .CW(CNT_W)) u_tally (
    .clk      (clk),
    .rst      (rst),
    .active   (mode == MODE_ON),
    .press    (press_i),
    .count    (count_o),
    .at_limit (expire)
  );

  assign on_o = (mode == MODE_ON);

  p_off_means_zero_r8: assert property (@(posedge clk) disable iff (rst)
    !on_o |-> (count_o == '0));

  p_reset_wins_r9: assert property (@(posedge clk)
    rst |=> (!on_o && count_o == '0));
endmodule

// File: tb/pb_autooff_switch_test.sv
module pb_autooff_switch_test;
  localparam int LIMIT = 10;
  localparam int CW = $clog2(LIMIT + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic press = 1'b0;
  logic on_o;
  logic [CW-1:0] count_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int m_on = 0;
  int m_cnt = 0;

  always #5 clk = ~clk;

  pb_autooff_switch #(.LIMIT(LIMIT)) uut (
    .clk(clk), .rst(rst), .press_i(press), .on_o(on_o), .count_o(count_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input bit p, input bit r);
    string tag;
    press = p;
    rst = r;
    @(posedge clk);
    if (r)                          begin tag = "R9/R1"; m_on = 0; m_cnt = 0; end
    else if (m_on == 0 && p)        begin tag = "R2"; m_on = 1; end
    else if (m_on == 0)             begin tag = "R3"; end
    else if (p)                     begin tag = "R5"; m_on = 0; m_cnt = 0; end
    else if (m_cnt >= LIMIT)        begin tag = "R6"; m_on = 0; m_cnt = 0; end
    else                            begin tag = "R4"; m_cnt++; end
    @(negedge clk);
    check({tag, " on"}, int'(on_o), m_on);
    check({tag, " count"}, int'(count_o), m_cnt);
    check("R7 bound", int'(count_o <= LIMIT), 1);
    if (!on_o) check("R8 off zero", int'(count_o), 0);
  endtask

  initial begin
    step(0, 1); step(1, 1);           // R1, R9: reset holds with press
    step(0, 0); step(0, 0);           // R3 idle off
    step(1, 0);                       // R2 turn on
    for (int i = 0; i < 14; i++) step(0, 0); // R4 then R6 timeout, then R3
    step(1, 0); step(0, 0); step(0, 0); step(0, 0);
    step(1, 0);                       // R5 press mid-count
    for (int i = 0; i < 6; i++) step(1, 0);  // held button toggles
    step(0, 0);
    step(1, 0);
    for (int i = 0; i < 10; i++) step(0, 0); // count reaches LIMIT
    step(1, 0);                       // R5 press exactly at LIMIT
    step(1, 0); step(0, 0); step(0, 0);
    step(1, 1);                       // R9 reset while on with press
    step(0, 0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule